// File: doc/BRIEF.md
# Grouped Timer Channel Block

This block puts two or three down-counting timer channels behind a single byte-addressed register window. A shared run-control register holds one bit per channel; a channel counts only while its bit is set, and it keeps its count while the bit is clear. A one-bit output-control register is also provided and is brought out on a pin. Each channel drives its own interrupt line.

The address decoder sends an access either to one of the two shared registers or to one channel window. The channel windows start at 0x08, 0x14 and 0x20, and each one spans three words. A build parameter decides whether the third channel exists. Without it, the third window is unmapped, and a run-control write that sets the third bit is rejected as a whole. Reads are combinational from the current address. Writes take effect on the rising clock edge where `wr_en` is high.

Inside a channel, word 0 holds the reload value and word 1 holds the live count. Word 2 is the control word: bit 0 enables the interrupt, and bit 1 is the underflow flag.

Top module: `tmr_group`

## Requirements
- R1: After reset: output control 0, run control 0, every reload and count word all ones, every control word 0, every interrupt low.
- R2: Offset 0x00 stores only write-data bit 0; it reads back in bit 0 (all other bits zero) and drives `outctl_o`.
- R3: Offset 0x04 is the run-control register. Bit i runs channel i. It reads back the last accepted value masked to the implemented channel bits, and it changes only on a write to 0x04.
- R4: Channel i window bases are 0x08, 0x14 and 0x20. The word index is (address - base) >> 2, giving word 0 = reload, word 1 = count and word 2 = control. A write to one channel leaves the other channels unchanged.
- R5: Offsets 0x01-0x03, 0x05-0x07 and everything from the end of the last implemented window upward (0x2C with three channels) read zero, and writes to them change nothing.
- R6: With the third channel disabled, its window 0x20-0x2B is unmapped, and a run-control write with bit 2 set is discarded whole, so it neither starts any channel nor changes the register.
- R7: A channel whose run bit is clear holds its count. When the bit is set again, counting resumes from the held value.
- R8: A running channel decrements once per clock. On the clock where its count is zero, it loads the reload value and sets its underflow flag.
- R9: A channel interrupt equals underflow flag AND enable. A control write with bit 1 = 0 clears the flag and with bit 1 = 1 leaves it. An underflow in the same cycle sets the flag regardless.
- R10: A write to a channel's count word on a clock where that channel runs loads the written value instead of decrementing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| addr | input | AW (8) | Byte address of the access |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for `addr`, combinational |
| outctl_o | output | 1 | Stored output-control bit |
| irq | output | 3 | Per-channel interrupt; bit 2 is tied low without the third channel |

## Verification
A decoder fault sends an access to the wrong register. It shows up as an unexpected or missing read-back value, or as a write that leaks into another channel; the fault is visible on the very next read, with no clock needed. A wrong run-control state causes extra or missing decrements. These show up as a count that is off by a known number of clocks, or as an interrupt arriving one or more cycles early or late. The stop, resume and underflow tests therefore check exact counts at fixed clock offsets.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int MAX_CH   = 3;
    localparam int OFF_OCTL = 'h00;
    localparam int OFF_RUN  = 'h04;
    localparam int WIN_SIZE = 'h0C;

    // window bases are uneven; decode depends on them
    localparam int WIN_BASE [MAX_CH] = '{'h08, 'h14, 'h20};

    typedef struct packed {
        logic              octl;
        logic              run;
        logic [MAX_CH-1:0] ch;
        logic [1:0]        word;
    } dec_t;

    typedef struct packed {
        logic              outctl;
        logic [MAX_CH-1:0] start;
    } ctl_t;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int AW      = 8,
    parameter bit HAS_CH2 = 1'b1
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);

    localparam int NCH = HAS_CH2 ? 3 : 2;

    always_comb begin
        dec = '0;
        if (addr == AW'(OFF_OCTL)) begin
            dec.octl = 1'b1;
        end else if (addr == AW'(OFF_RUN)) begin
            dec.run = 1'b1;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (addr >= AW'(WIN_BASE[i]) && addr < AW'(WIN_BASE[i] + WIN_SIZE)) begin
                    dec.ch[i] = 1'b1;
                    if (addr >= AW'(WIN_BASE[i] + 8))
                        dec.word = 2'd2;
                    else if (addr >= AW'(WIN_BASE[i] + 4))
                        dec.word = 2'd1;
                    else
                        dec.word = 2'd0;
                end
            end
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr,
    input  logic [1:0]    word,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] rld;
        logic          ie;
        logic          flag;
    } chan_t;

    chan_t st_d, st_q;
    logic  uflow;

    always_comb begin
        st_d  = st_q;
        uflow = run && (st_q.cnt == '0);
        if (run) begin
            if (uflow)
                st_d.cnt = st_q.rld;
            else
                st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr) begin
            case (word)
                2'd0: st_d.rld = wdata;
                2'd1: st_d.cnt = wdata;
                2'd2: begin
                    st_d.ie   = wdata[0];
                    st_d.flag = st_q.flag & wdata[1];
                end
                default: ;
            endcase
        end
        if (uflow)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.rld  <= '1;
            st_q.ie   <= 1'b0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (word)
            2'd0:    rdata = st_q.rld;
            2'd1:    rdata = st_q.cnt;
            2'd2:    rdata = {{(DW-2){1'b0}}, st_q.flag, st_q.ie};
            default: rdata = '0;
        endcase
    end

    assign irq = st_q.flag & st_q.ie;

endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter bit HAS_CH2 = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          outctl_o,
    output logic [2:0]    irq
);

    localparam int                NCH     = HAS_CH2 ? 3 : 2;
    localparam logic [MAX_CH-1:0] CH_MASK = MAX_CH'((1 << NCH) - 1);

    dec_t          dec;
    ctl_t          ctl_d, ctl_q;
    logic [DW-1:0] ch_rdata [MAX_CH];

    tmr_decode #(.AW(AW), .HAS_CH2(HAS_CH2)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && dec.octl)
            ctl_d.outctl = wdata[0];
        if (wr_en && dec.run) begin
            if (HAS_CH2 || !wdata[2])
                ctl_d.start = wdata[MAX_CH-1:0] & CH_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
        if (i < NCH) begin : g_on
            tmr_chan #(.DW(DW)) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .run   (ctl_q.start[i]),
                .wr    (wr_en && dec.ch[i]),
                .word  (dec.word),
                .wdata (wdata),
                .rdata (ch_rdata[i]),
                .irq   (irq[i])
            );
        end else begin : g_off
            assign ch_rdata[i] = '0;
            assign irq[i]      = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (dec.octl)
            rdata = {{(DW-1){1'b0}}, ctl_q.outctl};
        else if (dec.run)
            rdata = {{(DW-MAX_CH){1'b0}}, ctl_q.start};
        else begin
            for (int i = 0; i < MAX_CH; i++)
                if (dec.ch[i])
                    rdata = ch_rdata[i];
        end
    end

    assign outctl_o = ctl_q.outctl;

endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk #(
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter bit HAS_CH2 = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [2:0]    wlow,
    input logic [DW-1:0] rdata,
    input logic          outctl_o,
    input logic [2:0]    start_q
);

    localparam int MAP_END = HAS_CH2 ? 'h2C : 'h20;

    // R2: the output-control bit follows the last write to offset 0
    p_outctl_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(0)) |=> (outctl_o == $past(wlow[0])));

    // R3: run control changes only through its own offset
    p_start_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(4)) |=> $stable(start_q));

    // R5: addresses above the last window read zero
    p_high_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= AW'(MAP_END)) |-> (rdata == '0));

    // R5: gaps next to the shared registers read zero
    p_gap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr > AW'(0) && addr < AW'(4)) || (addr > AW'(4) && addr < AW'(8)))
        |-> (rdata == '0));

    // R6: a two-channel build never runs the third channel
    p_ch2_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_CH2) |-> !start_q[2]);

    // R6: a rejected run-control write leaves the register alone
    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_CH2 && wr_en && addr == AW'(4) && wlow[2]) |=> $stable(start_q));

endmodule

bind tmr_group tmr_group_chk #(.AW(AW), .DW(DW), .HAS_CH2(HAS_CH2)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wlow     (wdata[2:0]),
    .rdata    (rdata),
    .outctl_o (outctl_o),
    .start_q  (ctl_q.start)
);

// File: tb/tmr_group_tb.sv
module tmr_group_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata2;
    logic        outctl_o, outctl2;
    logic [2:0]  irq, irq2;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tmr_group u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .outctl_o(outctl_o), .irq(irq)
    );

    tmr_group #(.HAS_CH2(1'b0)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata2), .outctl_o(outctl2), .irq(irq2)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;    // write data, or expected read data
        logic [7:0]  tag;  // requirement number
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 32'h0000_0000, 8'd1},  // R1
        '{1'b0, 8'h04, 32'h0000_0000, 8'd1},  // R1
        '{1'b0, 8'h08, 32'hFFFF_FFFF, 8'd1},  // R1 reload
        '{1'b0, 8'h0C, 32'hFFFF_FFFF, 8'd1},  // R1 count
        '{1'b0, 8'h10, 32'h0000_0000, 8'd1},  // R1 control
        '{1'b0, 8'h28, 32'h0000_0000, 8'd1},  // R1 ch2 control
        '{1'b1, 8'h00, 32'hFFFF_FFFE, 8'd2},  // R2 bit0 = 0
        '{1'b0, 8'h00, 32'h0000_0000, 8'd2},
        '{1'b1, 8'h00, 32'h0000_0003, 8'd2},
        '{1'b0, 8'h00, 32'h0000_0001, 8'd2},  // R2 only bit0 kept
        '{1'b1, 8'h08, 32'h0000_1234, 8'd4},  // R4
        '{1'b1, 8'h14, 32'h0000_ABCD, 8'd4},
        '{1'b1, 8'h20, 32'h0000_0055, 8'd4},
        '{1'b0, 8'h08, 32'h0000_1234, 8'd4},
        '{1'b0, 8'h14, 32'h0000_ABCD, 8'd4},
        '{1'b0, 8'h20, 32'h0000_0055, 8'd4},
        '{1'b1, 8'h24, 32'h0000_0099, 8'd4},
        '{1'b0, 8'h24, 32'h0000_0099, 8'd4},
        '{1'b0, 8'h0C, 32'hFFFF_FFFF, 8'd4},  // R4 isolation
        '{1'b0, 8'h18, 32'hFFFF_FFFF, 8'd4},
        '{1'b1, 8'h2C, 32'h0000_0077, 8'd5},  // R5
        '{1'b0, 8'h2C, 32'h0000_0000, 8'd5},
        '{1'b0, 8'h30, 32'h0000_0000, 8'd5},
        '{1'b1, 8'h01, 32'h0000_0000, 8'd5},
        '{1'b1, 8'h07, 32'h0000_00FF, 8'd5},
        '{1'b0, 8'h01, 32'h0000_0000, 8'd5},
        '{1'b0, 8'h05, 32'h0000_0000, 8'd5},
        '{1'b0, 8'h00, 32'h0000_0001, 8'd5},  // R5 write to 0x01 ignored
        '{1'b0, 8'h04, 32'h0000_0000, 8'd5},  // R5 write to 0x07 ignored
        '{1'b1, 8'h04, 32'h0000_00F8, 8'd3},  // R3 bits above 2 masked
        '{1'b0, 8'h04, 32'h0000_0000, 8'd3},
        '{1'b0, 8'h2B, 32'h0000_0000, 8'd4}   // R4 ch2 control word
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // called just after a falling edge; consumes one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
        addr = a;
        #2;
        check(req, rdata, exp);
    endtask

    task automatic rd2(input logic [7:0] a, input string req, input logic [31:0] exp);
        addr = a;
        #2;
        check(req, rdata2, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset outputs
        check("R1", {28'h0, outctl_o, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr)
                wr(VEC[i].a, VEC[i].d);
            else
                rd(VEC[i].a, $sformatf("R%0d", VEC[i].tag), VEC[i].d);
        end

        // R2 pin follows register
        check("R2", {31'h0, outctl_o}, 32'h1);
        wr(8'h00, 32'h0);
        check("R2", {31'h0, outctl_o}, 32'h0);

        // R8 underflow and reload on channel 0
        wr(8'h08, 32'd5);
        wr(8'h0C, 32'd2);
        wr(8'h10, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, "R3", 32'h1);
        tick(2);
        rd(8'h0C, "R8", 32'd0);
        check("R8", {31'h0, irq[0]}, 32'h0);
        tick(1);
        check("R8", {31'h0, irq[0]}, 32'h1);
        rd(8'h0C, "R8", 32'd5);
        wr(8'h04, 32'h0);
        rd(8'h0C, "R8", 32'd4);

        // R7 hold then resume
        tick(5);
        rd(8'h0C, "R7", 32'd4);
        wr(8'h04, 32'h1);
        tick(2);
        wr(8'h04, 32'h0);
        rd(8'h0C, "R7", 32'd1);

        // R10 count write beats decrement
        wr(8'h04, 32'h1);
        wr(8'h0C, 32'd100);
        rd(8'h0C, "R10", 32'd100);
        wr(8'h04, 32'h0);
        rd(8'h0C, "R10", 32'd99);

        // R9 flag and enable on channel 1
        wr(8'h1C, 32'h0);
        wr(8'h14, 32'd3);
        wr(8'h18, 32'd0);
        wr(8'h04, 32'h2);
        wr(8'h04, 32'h0);
        rd(8'h18, "R9", 32'd3);
        rd(8'h1C, "R9", 32'h2);
        check("R9", {31'h0, irq[1]}, 32'h0);
        wr(8'h1C, 32'h3);
        check("R9", {31'h0, irq[1]}, 32'h1);
        wr(8'h1C, 32'h1);
        check("R9", {31'h0, irq[1]}, 32'h0);
        rd(8'h1C, "R9", 32'h1);

        // R9 underflow wins over a clear in the same cycle (channel 0)
        wr(8'h10, 32'h1);
        rd(8'h10, "R9", 32'h1);
        wr(8'h0C, 32'd0);
        wr(8'h04, 32'h1);
        wr(8'h10, 32'h1);
        check("R9", {31'h0, irq[0]}, 32'h1);
        wr(8'h04, 32'h0);
        rd(8'h10, "R9", 32'h3);
        rd(8'h0C, "R9", 32'd4);

        // R6 two-channel build
        wr(8'h0C, 32'd50);
        wr(8'h04, 32'h7);
        tick(3);
        rd2(8'h04, "R6", 32'h0);
        rd2(8'h0C, "R6", 32'd50);
        rd(8'h04, "R6", 32'h7);
        wr(8'h04, 32'h3);
        rd2(8'h04, "R6", 32'h3);
        wr(8'h04, 32'h4);
        rd2(8'h04, "R6", 32'h3);
        rd(8'h04, "R3", 32'h4);
        wr(8'h04, 32'h0);
        wr(8'h20, 32'h1234);
        rd2(8'h20, "R6", 32'h0);
        rd(8'h20, "R4", 32'h1234);
        check("R6", {29'h0, irq2[2], 2'b0}, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule